// File: doc/BRIEF.md
# Row Logical Index Mapper

This block serves one row of a rectangular processor array whose redundancy is used by logically deleting whole diagonals of cells. A host has already picked the set of deleted diagonals. For each row it hands over the row number, the row's diagnostic bits (1 marks a faulty cell) and a mask of the deleted diagonals. The block then streams one result per clock, from the leftmost column to the rightmost. Each result carries the cell's logical column index and the two-bit switch setting that splices the surviving cells of the row together around the removed ones.

A cell is unmapped in three cases: it is faulty, it lies on a deleted diagonal, or it is a survivor beyond the target row width. The target width is the column count less the spare columns, and a surplus survivor of this kind is a spare. Unmapped cells get the null index 0. Mapped cells are numbered 1, 2, 3 and so on from left to right. On the final beat of a row the block raises a shortfall flag when too few cells survive to fill the target width.

Top module: `rlm_row_mapper`

## Requirements
- R1: While reset is held (active low), and in the cycle after it is applied, `cellValid` and `busy` are 0.
- R2: When `rowStart` is high in a cycle with `busy` low, the block emits COLS beats in the COLS cycles that follow. Beat k has `cellCol` = k, `cellValid` = 1, and `cellLast` = 1 only when k = COLS-1. After the final beat `cellValid` returns to 0.
- R3: With zero-based row r and column c, the cell lies on diagonal c - r + ROWS - 1, which is bit (c - r + ROWS - 1) of `diagDel`. Diagonal 0 is the corner cell at row ROWS-1, column 0. The cell is removed when that bit is 1.
- R4: A cell whose `faultRow` bit c is 1 is removed.
- R5: Cells that are not removed get logical indices 1, 2, 3 and so on in ascending column order. Removed cells get index 0.
- R6: Survivors after the first COLS-SPARE_COLS survivors of the row are spares and get index 0. No index exceeds COLS-SPARE_COLS.
- R7: `cellSwitch` bit 1 is 1 when the cell's index is 0. Bit 0 is 1 when the index of the cell to its right is 0, and the rightmost cell treats the row edge as mapped. This gives 00 = pass to the right neighbour, 01 = cell onto the bypass, 10 = bypass onto the neighbour, 11 = bypass to bypass.
- R8: `rowShort` is 1 on the final beat exactly when fewer than COLS-SPARE_COLS cells of the row escape R3 and R4. It is 0 on every other beat.
- R9: A `rowStart` that arrives while `busy` is high is ignored, together with the data that comes with it. The beats already in progress continue unchanged, and no new row follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rowStart | input | 1 | Begin a row; sampled with the row data |
| rowSel | input | $clog2(ROWS) | Zero-based row number, below ROWS |
| faultRow | input | COLS | Diagnostic bits, bit c = column c, 1 = faulty |
| diagDel | input | ROWS+COLS-1 | Deleted-diagonal mask, bit d = diagonal d |
| busy | output | 1 | A row is being streamed |
| cellValid | output | 1 | Current beat carries a cell result |
| cellCol | output | $clog2(COLS) | Physical column of the current beat |
| cellLogIdx | output | $clog2(COLS+1) | Logical index, 0 = null |
| cellSwitch | output | 2 | Row switch code of the current cell |
| cellLast | output | 1 | Final beat of the row |
| rowShort | output | 1 | Row cannot fill the target width (final beat only) |

## Verification
The assertions assume that `rowSel` stays below ROWS. If it does not, the diagonal arithmetic reads outside the mask. The stimulus table and the directed tests only use row numbers from 0 to ROWS-1. They also hold the row data steady during the cycle in which `rowStart` is accepted. The neighbour-code check assumes that consecutive beats come from the same row. This holds because a start request during a row is ignored, and the bench deliberately presents one mid-row to show this.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
  typedef enum logic {RLM_IDLE, RLM_STREAM} rlmState_t;

  typedef struct packed {
    logic load;
    logic advance;
    logic lastBeat;
  } ctrlStrobe_t;
endpackage

// File: rtl/rlm_ctrl.sv
module rlm_ctrl
  import rlm_pkg::*;
#(
  parameter int COLS = 8,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rowStart,
  output ctrlStrobe_t   strobe,
  output logic          streaming,
  output logic [CW-1:0] colIdx
);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  rlmState_t state;

  always_comb begin
    streaming       = (state == RLM_STREAM);
    strobe.load     = rowStart && (state == RLM_IDLE);
    strobe.advance  = streaming;
    strobe.lastBeat = streaming && (colIdx == LAST_COL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RLM_IDLE;
      colIdx <= '0;
    end else if (strobe.load) begin
      state  <= RLM_STREAM;
      colIdx <= '0;
    end else if (strobe.lastBeat) begin
      state  <= RLM_IDLE;
      colIdx <= '0;
    end else if (strobe.advance) begin
      colIdx <= colIdx + CW'(1);
    end
  end

  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> streaming && colIdx == '0);
  assert_last_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.lastBeat |=> !streaming);
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    streaming && rowStart && !strobe.lastBeat |=> streaming && colIdx == CW'($past(colIdx) + CW'(1)));
endmodule

// File: rtl/rlm_datapath.sv
module rlm_datapath
  import rlm_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  parameter int SPARE_COLS = 2,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int DIAGS = ROWS + COLS - 1,
  localparam int DW = (DIAGS > 1) ? $clog2(DIAGS) : 1,
  localparam int LW = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [CW-1:0]    colIdx,
  input  logic [RW-1:0]    rowSel,
  input  logic [COLS-1:0]  faultRow,
  input  logic [DIAGS-1:0] diagDel,
  output logic [LW-1:0]    cellLogIdx,
  output logic [1:0]       cellSwitch,
  output logic             rowShort
);
  localparam logic [LW-1:0] TARGET = LW'(COLS - SPARE_COLS);

  logic [RW-1:0]    rowReg;
  logic [COLS-1:0]  faultReg;
  logic [DIAGS-1:0] delReg;
  logic [LW-1:0]    rankReg;
  logic [COLS-1:0]  survVec;
  logic [COLS-1:0]  survRight;
  logic [LW-1:0]    survTotal;
  logic             curSurv, keepCur, keepNext;
  logic [LW-1:0]    rankNext;

  for (genvar c = 0; c < COLS; c++) begin : g_cell
    localparam int BASE = c + ROWS - 1;
    logic [DW-1:0] diagIdx;
    assign diagIdx    = DW'(BASE) - DW'(rowReg);
    assign survVec[c] = !faultReg[c] && !delReg[diagIdx];
  end

  assign survRight = {1'b1, survVec[COLS-1:1]};

  always_comb begin
    survTotal = '0;
    for (int c = 0; c < COLS; c++) survTotal = survTotal + LW'(survVec[c]);
  end

  always_comb begin
    curSurv  = survVec[colIdx];
    rankNext = rankReg + LW'(curSurv);
    keepCur  = curSurv && (rankReg < TARGET);
    keepNext = strobe.lastBeat || (survRight[colIdx] && (rankNext < TARGET));
    if (strobe.advance) begin
      cellLogIdx = keepCur ? rankReg + LW'(1) : '0;
      cellSwitch = {!keepCur, !keepNext};
    end else begin
      cellLogIdx = '0;
      cellSwitch = 2'b00;
    end
    rowShort = strobe.lastBeat && (survTotal < TARGET);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowReg   <= '0;
      faultReg <= '0;
      delReg   <= '0;
      rankReg  <= '0;
    end else if (strobe.load) begin
      rowReg   <= rowSel;
      faultReg <= faultRow;
      delReg   <= diagDel;
      rankReg  <= '0;
    end else if (strobe.advance) begin
      rankReg  <= rankNext;
    end
  end

  assert_mapped_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && cellLogIdx != '0 |-> !cellSwitch[1]);
  assert_neighbour_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && $past(strobe.advance) && !$past(strobe.lastBeat)
      |-> $past(cellSwitch[0]) == (cellLogIdx == '0));
  assert_index_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && $past(strobe.advance) && !$past(strobe.lastBeat)
      && cellLogIdx != '0 && $past(cellLogIdx) != '0
      |-> cellLogIdx == LW'($past(cellLogIdx) + LW'(1)));
  assert_index_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cellLogIdx <= TARGET);
  assert_short_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rowShort |-> strobe.lastBeat);
endmodule

// File: rtl/rlm_row_mapper.sv
module rlm_row_mapper
  import rlm_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  parameter int SPARE_COLS = 2,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int DIAGS = ROWS + COLS - 1,
  localparam int LW = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rowStart,
  input  logic [RW-1:0]    rowSel,
  input  logic [COLS-1:0]  faultRow,
  input  logic [DIAGS-1:0] diagDel,
  output logic             busy,
  output logic             cellValid,
  output logic [CW-1:0]    cellCol,
  output logic [LW-1:0]    cellLogIdx,
  output logic [1:0]       cellSwitch,
  output logic             cellLast,
  output logic             rowShort
);
  ctrlStrobe_t strobe;
  logic        streaming;
  logic [CW-1:0] colIdx;

  rlm_ctrl #(.COLS(COLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rowStart(rowStart),
    .strobe(strobe), .streaming(streaming), .colIdx(colIdx)
  );

  rlm_datapath #(.ROWS(ROWS), .COLS(COLS), .SPARE_COLS(SPARE_COLS)) u_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .colIdx(colIdx),
    .rowSel(rowSel), .faultRow(faultRow), .diagDel(diagDel),
    .cellLogIdx(cellLogIdx), .cellSwitch(cellSwitch), .rowShort(rowShort)
  );

  assign busy      = streaming;
  assign cellValid = streaming;
  assign cellCol   = colIdx;
  assign cellLast  = strobe.lastBeat;
endmodule

// File: tb/rlm_row_mapper_bench.sv
module rlm_row_mapper_bench;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int SPARE = 2;
  localparam int TARGET = COLS - SPARE;
  localparam int DIAGS = ROWS + COLS - 1;
  localparam int NVEC = 7;

  // {row[1:0], fault[7:0], diag mask[10:0], expected shortfall}
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd0, 8'h00, 11'h000, 1'b0},
    {2'd2, 8'h81, 11'h000, 1'b0},
    {2'd1, 8'h00, 11'h088, 1'b0},
    {2'd3, 8'h10, 11'h201, 1'b0},
    {2'd0, 8'h0F, 11'h400, 1'b1},
    {2'd2, 8'h00, 11'h7FF, 1'b1},
    {2'd1, 8'h02, 11'h000, 1'b0}
  };

  logic clk = 0, rst_n = 0, rowStart = 0;
  logic [1:0] rowSel = '0;
  logic [COLS-1:0] faultRow = '0;
  logic [DIAGS-1:0] diagDel = '0;
  logic busy, cellValid, cellLast, rowShort;
  logic [2:0] cellCol;
  logic [3:0] cellLogIdx;
  logic [1:0] cellSwitch;

  int checks = 0, errors = 0, cycles = 0;
  int expIdx [COLS];
  int expSw [COLS];
  int expShort;

  always #4 clk = ~clk;

  rlm_row_mapper #(.ROWS(ROWS), .COLS(COLS), .SPARE_COLS(SPARE)) u_rlm_row_mapper (
    .clk(clk), .rst_n(rst_n), .rowStart(rowStart), .rowSel(rowSel),
    .faultRow(faultRow), .diagDel(diagDel), .busy(busy), .cellValid(cellValid),
    .cellCol(cellCol), .cellLogIdx(cellLogIdx), .cellSwitch(cellSwitch),
    .cellLast(cellLast), .rowShort(rowShort)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(int r, logic [COLS-1:0] f, logic [DIAGS-1:0] d);
    int rank = 0;
    for (int c = 0; c < COLS; c++) begin
      int dg = c - r + ROWS - 1;
      expIdx[c] = 0;
      if (!f[c] && !d[dg]) begin
        rank++;
        if (rank <= TARGET) expIdx[c] = rank;
      end
    end
    expShort = (rank < TARGET) ? 1 : 0;
    for (int c = 0; c < COLS; c++) begin
      int nb = (c == COLS - 1) ? 0 : (expIdx[c+1] == 0);
      expSw[c] = ((expIdx[c] == 0) ? 2 : 0) + nb;
    end
  endtask

  // midBeat >= 0: raise rowStart with other data during that beat (R9)
  task automatic runRow(logic [1:0] r, logic [COLS-1:0] f, logic [DIAGS-1:0] d, int midBeat);
    model(r, f, d);
    @(negedge clk);
    rowSel = r; faultRow = f; diagDel = d; rowStart = 1;
    @(negedge clk);
    rowStart = 0; faultRow = ~f; diagDel = ~d;
    for (int k = 0; k < COLS; k++) begin
      chk("R2 valid", cellValid, 1);
      chk("R2 col", cellCol, k);
      chk("R2 last", cellLast, (k == COLS - 1));
      chk("R3/R4/R5/R6 index", cellLogIdx, expIdx[k]);
      chk("R7 switch", cellSwitch, expSw[k]);
      chk("R8 short", rowShort, (k == COLS - 1) ? expShort : 0);
      rowStart = (k == midBeat);
      @(negedge clk);
      rowStart = 0;
    end
    chk("R2/R9 idle after row", cellValid, 0);
    chk("R9 not busy", busy, 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 20000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", cellValid, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", cellValid, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [21:0] e = VEC[v];
      runRow(e[21:20], e[19:12], e[11:1], -1);
      chk("R8 table shortfall", expShort, int'(e[0]));
    end

    // R9: start during row (mid and last beat) is ignored
    runRow(2'd1, 8'h20, 11'h010, 2);
    runRow(2'd3, 8'h00, 11'h004, COLS - 1);

    // R1: reset applied mid-row
    @(negedge clk);
    rowSel = 2'd0; faultRow = '0; diagDel = '0; rowStart = 1;
    @(negedge clk);
    rowStart = 0;
    repeat (2) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 valid after mid-row reset", cellValid, 0);
    chk("R1 busy after mid-row reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 stays idle", cellValid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule